// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces refresh for an external DRAM. An 8-bit interval counter advances on each prescaler strobe. When it reaches a programmable limit, it wraps to zero and sets a sticky match flag. If refresh is enabled and the auto mode is selected, the same event sends a one-cycle refresh request to the DRAM sequencer. A 10-bit refresh tally counts the requests that are issued. It wraps at one of two selectable limits and sets a sticky overflow flag when it does.

Software reaches four registers over a 16-bit register bus with a one-cycle read latency. Two of them are guarded. The limit register takes a write only as a 16-bit word carrying an 8-bit key in its top byte. The tally register takes a write only when the top six bits of the word carry a 6-bit key. Power-on reset clears everything. Manual reset blocks the bus and clears the read data, but leaves the timing chain running, so DRAM contents survive it. Standby freezes the counting.

Top module: `refresh_timer`

## Requirements
- R1: Power-on reset (`por_rst`, synchronous, active high) clears the control, interval, limit and tally registers, `bus_rdata` and `refresh_req` to zero.
- R2: The interval count advances by one on a cycle with `presc_tick` high, provided the clock-select field (control bits [2:0]) is nonzero and `standby` is low. It holds while the clock-select field is zero.
- R3: On an advancing tick where the interval count equals the limit, the count returns to 0 and the match flag (control bit 3) sets. The period is therefore limit+1 ticks.
- R4: `refresh_req` pulses high for one cycle, in the cycle after a match. It pulses only if refresh enable (control bit 6) and auto mode (control bit 7) were both 1.
- R5: The limit register (address 2) loads `bus_wdata[7:0]` only on a word write (`bus_word`=1) whose `bus_wdata[15:8]` is 0xA5. A wrong key or a byte write leaves it unchanged. It reads back with bits [15:8] zero.
- R6: The tally register (address 3) increments once per issued refresh request. It loads `bus_wdata[9:0]` only on a word write whose `bus_wdata[15:10]` is 101001b. Other writes are ignored.
- R7: Control bit 5 selects the tally limit: 0 gives 1024 and 1 gives 512. An increment from limit-1 wraps the tally to 0 and sets the overflow flag (control bit 4).
- R8: The match and overflow flags stay set until a control write (address 0) carries 0 in that bit position. Writing 1 leaves a flag unchanged. A control write loads bits [2:0], 5, 6 and 7 directly.
- R9: While `standby` is high, ticks are ignored. The interval and tally counts hold, and no request is issued.
- R10: While `man_rst` is high, bus writes are ignored and `bus_rdata` reads 0. The limit and control settings keep their values, and interval counting and refresh requests continue.
- R11: A read (`bus_rd` high) returns the addressed register on `bus_rdata` in the next cycle. The map is: 0 control, 1 interval count, 2 limit, 3 tally. Unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| standby | input | 1 | Freeze counting |
| presc_tick | input | 1 | Prescaler enable strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_word | input | 1 | 1 = 16-bit access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| refresh_req | output | 1 | One-cycle refresh request |

## Verification
A corrupted interval count shows at the ports as a shifted spacing of `refresh_req` pulses, from the next match onward. A read of address 1 exposes it one cycle after the read. A tally that is stuck or wraps at the wrong point shows as a wrong overflow bit, at the latest by the refresh that should have wrapped it. A key comparator that leaks shows up at once as a changed read-back after a rejected write. A manual-reset path that resets too much shows as lost limit or tally values on the first read after release.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam int CKS_W = 3;

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_IVL = 2'd1;
  localparam logic [1:0] A_LIM = 2'd2;
  localparam logic [1:0] A_CNT = 2'd3;

  typedef struct packed {
    logic             auto_mode;
    logic             ref_en;
    logic             lim_sel;
    logic             ovf;
    logic             cmf;
    logic [CKS_W-1:0] cks;
  } ctl_t;
endpackage

// File: rtl/rft_keygate.sv
module rft_keygate #(
  parameter int              KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY  = '0
) (
  input  logic             wr,
  input  logic             word,
  input  logic [KEY_W-1:0] key_field,
  output logic             accept
);
  assign accept = wr && word && (key_field == KEY);
endmodule

// File: rtl/rft_interval.sv
module rft_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         match
);
  assign match = run && (count == limit);

  always_ff @(posedge clk) begin
    if (por_rst)    count <= '0;
    else if (match) count <= '0;
    else if (run)   count <= count + 1'b1;
  end
endmodule

// File: rtl/rft_refcount.sv
module rft_refcount #(
  parameter int W      = 10,
  parameter int LIM_HI = 1024,
  parameter int LIM_LO = 512
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         inc,
  input  logic         lim_sel,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         ovf_evt
);
  localparam logic [W-1:0] TOP_HI = W'(LIM_HI - 1);
  localparam logic [W-1:0] TOP_LO = W'(LIM_LO - 1);

  logic [W-1:0] top;
  assign top     = lim_sel ? TOP_LO : TOP_HI;
  assign ovf_evt = inc && !load && (count == top);

  always_ff @(posedge clk) begin
    if (por_rst)      count <= '0;
    else if (load)    count <= load_val;
    else if (ovf_evt) count <= '0;
    else if (inc)     count <= count + 1'b1;
  end
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rft_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IVL_W  = 8,
  parameter int CNT_W  = 10,
  parameter int LIM_HI = 1024,
  parameter int LIM_LO = 512
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              standby,
  input  logic              presc_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_word,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              refresh_req
);
  localparam int LKEY_W = DATA_W - IVL_W;
  localparam int CKEY_W = DATA_W - CNT_W;
  localparam int CTL_W  = $bits(ctl_t);

  ctl_t             ctl_q;
  logic [CTL_W-1:0] ctl_bits;
  logic [IVL_W-1:0] lim_q;
  logic [IVL_W-1:0] ivl_cnt;
  logic [CNT_W-1:0] ref_cnt;
  logic             bus_ok, ctl_we, lim_we, cnt_we;
  logic             run, match, fire, ovf_evt;
  logic [DATA_W-1:0] rd_mux;

  assign bus_ok   = bus_wr && !man_rst;
  assign ctl_we   = bus_ok && (bus_addr == A_CTL);
  assign ctl_bits = ctl_q;

  rft_keygate #(.KEY_W(LKEY_W), .KEY(LKEY_W'(8'hA5))) u_lim_key (
    .wr(bus_ok && (bus_addr == A_LIM)), .word(bus_word),
    .key_field(bus_wdata[DATA_W-1 -: LKEY_W]), .accept(lim_we));

  rft_keygate #(.KEY_W(CKEY_W), .KEY(CKEY_W'(6'b101001))) u_cnt_key (
    .wr(bus_ok && (bus_addr == A_CNT)), .word(bus_word),
    .key_field(bus_wdata[DATA_W-1 -: CKEY_W]), .accept(cnt_we));

  assign run  = presc_tick && (ctl_q.cks != '0) && !standby;
  assign fire = match && ctl_q.ref_en && ctl_q.auto_mode;

  rft_interval #(.W(IVL_W)) u_ivl (
    .clk(clk), .por_rst(por_rst), .run(run), .limit(lim_q),
    .count(ivl_cnt), .match(match));

  rft_refcount #(.W(CNT_W), .LIM_HI(LIM_HI), .LIM_LO(LIM_LO)) u_cnt (
    .clk(clk), .por_rst(por_rst), .inc(fire), .lim_sel(ctl_q.lim_sel),
    .load(cnt_we), .load_val(bus_wdata[CNT_W-1:0]),
    .count(ref_cnt), .ovf_evt(ovf_evt));

  always_ff @(posedge clk) begin
    if (por_rst) begin
      ctl_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.cks       <= bus_wdata[CKS_W-1:0];
        ctl_q.lim_sel   <= bus_wdata[5];
        ctl_q.ref_en    <= bus_wdata[6];
        ctl_q.auto_mode <= bus_wdata[7];
        ctl_q.cmf       <= (ctl_q.cmf && bus_wdata[3]) || match;
        ctl_q.ovf       <= (ctl_q.ovf && bus_wdata[4]) || ovf_evt;
      end else begin
        ctl_q.cmf <= ctl_q.cmf || match;
        ctl_q.ovf <= ctl_q.ovf || ovf_evt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst)     lim_q <= '0;
    else if (lim_we) lim_q <= bus_wdata[IVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (por_rst) refresh_req <= 1'b0;
    else         refresh_req <= fire;
  end

  always_comb begin
    unique case (bus_addr)
      A_CTL:   rd_mux = {{(DATA_W-CTL_W){1'b0}}, ctl_bits};
      A_IVL:   rd_mux = {{(DATA_W-IVL_W){1'b0}}, ivl_cnt};
      A_LIM:   rd_mux = {{(DATA_W-IVL_W){1'b0}}, lim_q};
      default: rd_mux = {{(DATA_W-CNT_W){1'b0}}, ref_cnt};
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_rst || man_rst) bus_rdata <= '0;
    else if (bus_rd)        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/rft_checker.sv
module rft_checker #(
  parameter int DATA_W = 16,
  parameter int IVL_W  = 8,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              por_rst,
  input logic              man_rst,
  input logic              standby,
  input logic              refresh_req,
  input logic [7:0]        ctl_bits,
  input logic [IVL_W-1:0]  ivl_cnt,
  input logic [IVL_W-1:0]  lim_q,
  input logic [CNT_W-1:0]  ref_cnt,
  input logic [DATA_W-1:0] bus_rdata
);
  p_req_gate_r4: assert property (@(posedge clk) disable iff (por_rst)
    refresh_req |-> $past(ctl_bits[6] && ctl_bits[7]));

  p_ivl_stop_r2: assert property (@(posedge clk) disable iff (por_rst)
    (ctl_bits[2:0] == 3'd0) |=> $stable(ivl_cnt));

  p_stby_hold_r9: assert property (@(posedge clk) disable iff (por_rst)
    standby |=> ($stable(ivl_cnt) && !refresh_req));

  p_lim_keep_r10: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> $stable(lim_q));

  p_rd_clear_r10: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> (bus_rdata == '0));

  p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (por_rst)
    $rose(ctl_bits[4]) |-> (ref_cnt == '0));
endmodule

bind refresh_timer rft_checker #(.DATA_W(DATA_W), .IVL_W(IVL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .standby(standby),
  .refresh_req(refresh_req), .ctl_bits(ctl_bits), .ivl_cnt(ivl_cnt),
  .lim_q(lim_q), .ref_cnt(ref_cnt), .bus_rdata(bus_rdata));

// File: tb/sim_refresh_timer.sv
module sim_refresh_timer;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, man_rst = 1'b0, standby = 1'b0, presc_tick = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        refresh_req;
  logic        rd_d = 1'b0;
  int          n_chk = 0, n_fail = 0, req_seen = 0;
  bit          done = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  refresh_timer u0 (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .standby(standby),
    .presc_tick(presc_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .refresh_req(refresh_req));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (refresh_req) req_seen++;
    if (rd_d) begin
      if (q.size() == 0) chk("R11 read without expectation", 16'h1, 16'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d, logic w);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_word = w;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    @(negedge clk);
    q.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      presc_tick = 1'b1;
    end
    @(negedge clk);
    presc_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0x0001 expected 0x0000");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    chk("R1 rdata after reset", bus_rdata, 16'h0);
    chk("R1 req after reset", {15'd0, refresh_req}, 16'h0);
    rd(2'd0, 16'h0000, "R1 ctl reset");
    rd(2'd1, 16'h0000, "R1 ivl reset");
    rd(2'd2, 16'h0000, "R1 lim reset");
    rd(2'd3, 16'h0000, "R1 cnt reset");

    wr(2'd2, 16'h5A07, 1'b1);
    rd(2'd2, 16'h0000, "R5 bad key ignored");
    wr(2'd2, 16'hA507, 1'b0);
    rd(2'd2, 16'h0000, "R5 byte write ignored");
    wr(2'd2, 16'hA503, 1'b1);
    rd(2'd2, 16'h0003, "R5 keyed write loads");

    tick_n(3);
    rd(2'd1, 16'h0000, "R2 clock select zero holds");

    base = req_seen;
    wr(2'd0, 16'h00C1, 1'b0);
    tick_n(4);
    chk("R4 one request per match", 16'(req_seen - base), 16'd1);
    rd(2'd1, 16'h0000, "R3 wrap to zero");
    rd(2'd0, 16'h00C9, "R3 match flag set");
    rd(2'd3, 16'h0001, "R6 tally incremented");

    tick_n(2);
    rd(2'd1, 16'h0002, "R2 interval advances");

    wr(2'd0, 16'h00C9, 1'b0);
    rd(2'd0, 16'h00C9, "R8 write one keeps flag");
    wr(2'd0, 16'h00C1, 1'b0);
    rd(2'd0, 16'h00C1, "R8 write zero clears flag");

    base = req_seen;
    wr(2'd0, 16'h0081, 1'b0);
    tick_n(2);
    chk("R4 no request when disabled", 16'(req_seen - base), 16'd0);
    rd(2'd0, 16'h0089, "R3 flag without request");
    rd(2'd3, 16'h0001, "R6 tally holds without request");

    wr(2'd3, 16'hA1FE, 1'b1);
    rd(2'd3, 16'h0001, "R6 bad key ignored");
    wr(2'd3, 16'hA5FE, 1'b1);
    rd(2'd3, 16'h01FE, "R6 keyed write loads");
    base = req_seen;
    wr(2'd0, 16'h00E1, 1'b0);
    tick_n(8);
    chk("R4 two requests", 16'(req_seen - base), 16'd2);
    rd(2'd3, 16'h0000, "R7 wrap at 512");
    rd(2'd0, 16'h00F9, "R7 overflow flag at 512");

    wr(2'd3, 16'hA7FF, 1'b1);
    wr(2'd0, 16'h00C1, 1'b0);
    rd(2'd0, 16'h00C1, "R8 both flags cleared");
    tick_n(4);
    rd(2'd3, 16'h0000, "R7 wrap at 1024");
    rd(2'd0, 16'h00D9, "R7 overflow flag at 1024");

    wr(2'd3, 16'hA5FF, 1'b1);
    wr(2'd0, 16'h00C1, 1'b0);
    tick_n(4);
    rd(2'd3, 16'h0200, "R7 no wrap at 512 when 1024 selected");
    rd(2'd0, 16'h00C9, "R7 no overflow flag");

    base = req_seen;
    @(negedge clk); standby = 1'b1;
    tick_n(3);
    chk("R9 no request in standby", 16'(req_seen - base), 16'd0);
    rd(2'd1, 16'h0000, "R9 interval holds in standby");
    rd(2'd3, 16'h0200, "R9 tally holds in standby");
    @(negedge clk); standby = 1'b0;
    tick_n(3);
    rd(2'd1, 16'h0003, "R2 resumes after standby");

    base = req_seen;
    @(negedge clk); man_rst = 1'b1;
    tick_n(1);
    wr(2'd3, 16'hA400, 1'b1);
    wr(2'd2, 16'hA509, 1'b1);
    @(negedge clk);
    chk("R10 rdata cleared", bus_rdata, 16'h0000);
    man_rst = 1'b0;
    chk("R10 refresh continues", 16'(req_seen - base), 16'd1);
    rd(2'd3, 16'h0201, "R10 tally kept and counted");
    rd(2'd2, 16'h0003, "R10 limit kept");
    rd(2'd1, 16'h0000, "R10 interval ran");

    @(negedge clk); por_rst = 1'b1;
    @(negedge clk); por_rst = 1'b0;
    rd(2'd0, 16'h0000, "R1 ctl after second reset");
    rd(2'd2, 16'h0000, "R1 lim after second reset");
    rd(2'd3, 16'h0000, "R1 cnt after second reset");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule